// File: doc/BRIEF.md
# Weighted Round-Robin Virtual-Channel Grant Arbiter

This block picks one of up to sixteen virtual channels to own a shared output in each cycle. It has three arbitration modes. In strict priority mode the highest-numbered requester wins. In fixed round-robin mode priority rotates past the last channel that was granted. In the table-driven weighted mode, a phase pointer walks a 32-slot schedule, and each slot names the channel that may be served in that slot.

Software never edits the live schedule directly. Its writes go into a staging copy that holds four 32-bit words. A separate load command copies the whole staging copy into the working schedule at once. A status flag stays high from the first staged write until a load takes it in. This means that reprogramming the weights cannot tear a schedule that is running.

The grant is combinational from the current request vector and the registered arbiter state. The phase pointer, the round-robin history and both copies of the table change only at the rising clock edge.

Top module: `vc_wrr_arbiter`

## Requirements
- R1: After reset, `tbl_pending` and `load_busy` are 0 and `phase_ptr` is 0. Both copies of the table hold all zeros, and the round-robin history points at channel 15, so the first search starts at channel 0. With no request, `gnt` is 0.
- R2: A write with `cfg_wr_en`=1 stores `cfg_wr_data` into staging word `cfg_wr_addr`. Word k holds phases 8k to 8k+7, and phase 8k+i sits in bits [4i+3:4i]. The write sets `tbl_pending` at the next edge. It leaves the working schedule unchanged until a load.
- R3: A `load_cmd` pulse raises `load_busy` for the following cycle. At the edge that ends that cycle, the working schedule takes the staging copy and `load_busy` falls. `tbl_pending` also clears at that edge.
- R4: A staged write made in the `load_busy` cycle keeps `tbl_pending` at 1. The copy taken at that edge holds the word's previous value.
- R5: Mode decode works as follows. `strict_en`=1 selects strict priority, whatever `mode_sel` holds. Otherwise `mode_sel`=3'b001 selects the weighted table mode, and any other value selects fixed round-robin.
- R6: In strict priority mode, `gnt` is the one-hot of the highest-numbered requesting channel.
- R7: In fixed round-robin mode, the search starts one above the last granted channel and wraps after channel 15. Every non-zero grant, in any mode, updates that history.
- R8: In weighted mode, `gnt` is the one-hot of the current slot's channel when that channel requests, and 0 otherwise. `phase_ptr` advances at every edge spent in weighted mode and wraps from 31 to 0. It holds in the other modes.
- R9: `gnt` has at most one bit set, and never grants a channel that is not requesting. In strict and round-robin modes, any request produces a grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| strict_en | input | 1 | Strict priority enable |
| mode_sel | input | 3 | Arbitration select; 3'b001 = weighted table |
| cfg_wr_en | input | 1 | Staging table word write strobe |
| cfg_wr_addr | input | 2 | Staging word index |
| cfg_wr_data | input | 32 | Staging word data, eight 4-bit slots |
| load_cmd | input | 1 | Load command pulse |
| req | input | 16 | Per-channel request |
| gnt | output | 16 | One-hot channel grant |
| phase_ptr | output | 5 | Current weighted-schedule phase |
| tbl_pending | output | 1 | Staged changes not yet loaded |
| load_busy | output | 1 | Copy to working schedule happens this cycle |

## Verification
A staged word write and the staging-to-working copy can fall in the same cycle. Staging register traffic and the live schedule overlap at that point. The bench provokes the overlap by issuing a write while `load_busy` is high. It then judges the result in two ways. First, `tbl_pending` must remain set. Second, a full 32-phase sweep under all-ones requests must still follow the word's old contents, until a second load makes the new contents appear. A separate sweep with a single requesting channel confirms that slots owned by idle channels pass without a grant, while the pointer keeps moving.

// File: rtl/vc_arb_pkg.sv
package vc_arb_pkg;

  typedef enum logic [1:0] {
    MODE_RR     = 2'd0,
    MODE_STRICT = 2'd1,
    MODE_WRR    = 2'd2
  } arb_mode_e;

  localparam logic [2:0] SEL_WRR32 = 3'b001;

  // Strict enable overrides the select field; only 001 picks the table mode
  function automatic arb_mode_e decode_mode(input logic strict_en,
                                            input logic [2:0] sel);
    if (strict_en)         return MODE_STRICT;
    else if (sel == SEL_WRR32) return MODE_WRR;
    else                   return MODE_RR;
  endfunction

endpackage

// File: rtl/vc_tbl_store.sv
module vc_tbl_store #(
  parameter int PHASES = 32,
  parameter int CH_W   = 4,
  parameter int DW     = 32,
  localparam int WORDS = (PHASES * CH_W) / DW,
  localparam int AW    = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int PH_W  = $clog2(PHASES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic            load_cmd,
  input  logic [PH_W-1:0] rd_phase,
  output logic [CH_W-1:0] rd_owner,
  output logic            pending,
  output logic            busy
);

  logic [DW-1:0]           stage_q [WORDS];
  logic [DW-1:0]           work_q  [WORDS];
  logic [WORDS*DW-1:0]     work_flat;
  logic                    pend_q;
  logic                    busy_q;

  // Busy lasts exactly one cycle per command: the copy cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= load_cmd;
  end

  // A write always wins over the clear done by the copy
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pend_q <= 1'b0;
    else if (wr_en)  pend_q <= 1'b1;
    else if (busy_q) pend_q <= 1'b0;
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[w] <= '0;
      end else if (wr_en && (int'(wr_addr) == w)) begin
        stage_q[w] <= wr_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      work_q[w] <= '0;
      else if (busy_q) work_q[w] <= stage_q[w];
    end

    assign work_flat[w*DW +: DW] = work_q[w];
  end

  assign rd_owner = work_flat[int'(rd_phase)*CH_W +: CH_W];
  assign pending  = pend_q;
  assign busy     = busy_q;

endmodule

// File: rtl/vc_wrr_phase.sv
module vc_wrr_phase #(
  parameter int PHASES = 32,
  parameter int NUM_CH = 16,
  parameter int CH_W   = 4,
  localparam int PH_W  = $clog2(PHASES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              advance,
  input  logic [CH_W-1:0]   owner,
  input  logic [NUM_CH-1:0] req,
  output logic [PH_W-1:0]   phase,
  output logic [NUM_CH-1:0] gnt
);

  logic [PH_W-1:0] phase_q;

  function automatic logic [PH_W-1:0] next_phase(input logic [PH_W-1:0] p);
    if (p == PH_W'(PHASES - 1)) return '0;
    else                        return p + 1'b1;
  endfunction

  function automatic logic [NUM_CH-1:0] slot_grant(input logic [CH_W-1:0] o,
                                                   input logic [NUM_CH-1:0] r);
    logic [NUM_CH-1:0] g;
    g = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (int'(o) == c) g[c] = r[c];
    end
    return g;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase_q <= '0;
    else if (advance) phase_q <= next_phase(phase_q);
  end

  assign phase = phase_q;
  assign gnt   = slot_grant(owner, req);

endmodule

// File: rtl/vc_pick.sv
module vc_pick #(
  parameter int NUM_CH = 16,
  localparam int IW    = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] req,
  input  logic              hist_upd,
  input  logic [IW-1:0]     hist_idx,
  output logic [NUM_CH-1:0] rr_gnt,
  output logic [NUM_CH-1:0] strict_gnt
);

  logic [IW-1:0] last_q;

  function automatic logic [NUM_CH-1:0] pick_highest(input logic [NUM_CH-1:0] r);
    logic [NUM_CH-1:0] g;
    logic              hit;
    g   = '0;
    hit = 1'b0;
    for (int c = NUM_CH - 1; c >= 0; c--) begin
      if (!hit && r[c]) begin
        g[c] = 1'b1;
        hit  = 1'b1;
      end
    end
    return g;
  endfunction

  function automatic logic [NUM_CH-1:0] pick_rotate(input logic [NUM_CH-1:0] r,
                                                    input logic [IW-1:0] last);
    logic [NUM_CH-1:0] g;
    logic              hit;
    int                idx;
    g   = '0;
    hit = 1'b0;
    for (int k = 1; k <= NUM_CH; k++) begin
      idx = (int'(last) + k) % NUM_CH;
      if (!hit && r[idx]) begin
        g[idx] = 1'b1;
        hit    = 1'b1;
      end
    end
    return g;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        last_q <= IW'(NUM_CH - 1);
    else if (hist_upd) last_q <= hist_idx;
  end

  assign rr_gnt     = pick_rotate(req, last_q);
  assign strict_gnt = pick_highest(req);

endmodule

// File: rtl/vc_wrr_arbiter.sv
module vc_wrr_arbiter #(
  parameter int NUM_CH = 16,
  parameter int CH_W   = 4,
  parameter int PHASES = 32,
  parameter int DW     = 32
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  strict_en,
  input  logic [2:0]                            mode_sel,
  input  logic                                  cfg_wr_en,
  input  logic [$clog2(PHASES*CH_W/DW)-1:0]     cfg_wr_addr,
  input  logic [DW-1:0]                         cfg_wr_data,
  input  logic                                  load_cmd,
  input  logic [NUM_CH-1:0]                     req,
  output logic [NUM_CH-1:0]                     gnt,
  output logic [$clog2(PHASES)-1:0]             phase_ptr,
  output logic                                  tbl_pending,
  output logic                                  load_busy
);
  import vc_arb_pkg::*;

  localparam int PH_W = $clog2(PHASES);
  localparam int IW   = $clog2(NUM_CH);

  arb_mode_e         mode;
  logic              wrr_active;
  logic              grant_fire;
  logic [CH_W-1:0]   slot_owner;
  logic [NUM_CH-1:0] wrr_gnt;
  logic [NUM_CH-1:0] rr_gnt;
  logic [NUM_CH-1:0] strict_gnt;
  logic [IW-1:0]     gnt_idx;

  function automatic logic [IW-1:0] onehot_index(input logic [NUM_CH-1:0] oh);
    logic [IW-1:0] i;
    i = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (oh[c]) i = IW'(c);
    end
    return i;
  endfunction

  assign mode       = decode_mode(strict_en, mode_sel);
  assign wrr_active = (mode == MODE_WRR);

  vc_tbl_store #(.PHASES(PHASES), .CH_W(CH_W), .DW(DW)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_wr_en),
    .wr_addr  (cfg_wr_addr),
    .wr_data  (cfg_wr_data),
    .load_cmd (load_cmd),
    .rd_phase (phase_ptr),
    .rd_owner (slot_owner),
    .pending  (tbl_pending),
    .busy     (load_busy)
  );

  vc_wrr_phase #(.PHASES(PHASES), .NUM_CH(NUM_CH), .CH_W(CH_W)) u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (wrr_active),
    .owner   (slot_owner),
    .req     (req),
    .phase   (phase_ptr),
    .gnt     (wrr_gnt)
  );

  vc_pick #(.NUM_CH(NUM_CH)) u_pick (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req),
    .hist_upd   (grant_fire),
    .hist_idx   (gnt_idx),
    .rr_gnt     (rr_gnt),
    .strict_gnt (strict_gnt)
  );

  always_comb begin
    unique case (mode)
      MODE_STRICT: gnt = strict_gnt;
      MODE_WRR:    gnt = wrr_gnt;
      default:     gnt = rr_gnt;
    endcase
  end

  assign grant_fire = |gnt;
  assign gnt_idx    = onehot_index(gnt);

endmodule

module vc_wrr_arbiter_chk #(
  parameter int NUM_CH = 16,
  parameter int PHASES = 32,
  localparam int PH_W  = $clog2(PHASES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] req,
  input logic [NUM_CH-1:0] gnt,
  input logic              cfg_wr_en,
  input logic              load_cmd,
  input logic              load_busy,
  input logic              tbl_pending,
  input logic [PH_W-1:0]   phase_ptr,
  input logic              wrr_active
);

  // R9
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  // R9
  gnt_in_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((gnt & ~req) == '0));

  // R9
  work_conserve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrr_active && (|req)) |-> (|gnt));

  // R2
  write_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_en |=> tbl_pending);

  // R3
  load_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_cmd |=> load_busy);

  // R3
  load_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_busy && !cfg_wr_en && !load_cmd) |=> (!tbl_pending && !load_busy));

  // R8
  phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrr_active |=> (phase_ptr == (($past(phase_ptr) == PH_W'(PHASES - 1)) ?
                                  '0 : $past(phase_ptr) + 1'b1)));

  // R8
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrr_active |=> $stable(phase_ptr));

endmodule

bind vc_wrr_arbiter vc_wrr_arbiter_chk #(.NUM_CH(NUM_CH), .PHASES(PHASES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req         (req),
  .gnt         (gnt),
  .cfg_wr_en   (cfg_wr_en),
  .load_cmd    (load_cmd),
  .load_busy   (load_busy),
  .tbl_pending (tbl_pending),
  .phase_ptr   (phase_ptr),
  .wrr_active  (wrr_active)
);

// File: tb/test_vc_wrr_arbiter.sv
module test_vc_wrr_arbiter;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        strict_en;
  logic [2:0]  mode_sel;
  logic        cfg_wr_en;
  logic [1:0]  cfg_wr_addr;
  logic [31:0] cfg_wr_data;
  logic        load_cmd;
  logic [15:0] req;
  logic [15:0] gnt;
  logic [4:0]  phase_ptr;
  logic        tbl_pending;
  logic        load_busy;

  int checks = 0;
  int errors = 0;
  int exp_phase = 0;
  logic [31:0] exp_words [4];

  always #(CLK_P/2) clk = ~clk;

  vc_wrr_arbiter i_vc_wrr_arbiter (
    .clk(clk), .rst_n(rst_n), .strict_en(strict_en), .mode_sel(mode_sel),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr), .cfg_wr_data(cfg_wr_data),
    .load_cmd(load_cmd), .req(req), .gnt(gnt), .phase_ptr(phase_ptr),
    .tbl_pending(tbl_pending), .load_busy(load_busy)
  );

  // Bench-side phase expectation (R8): steps at each edge spent in table mode
  always @(posedge clk) begin
    if (rst_n && !strict_en && mode_sel == 3'b001) exp_phase <= (exp_phase + 1) % 32;
  end

  // Vector layout: {strict, sel[2:0], req[15:0], expected gnt[15:0]}
  localparam logic [35:0] VEC [11] = '{
    36'h0_0011_0001, 36'h0_0011_0010, 36'h0_0011_0001, 36'h0_8000_8000,
    36'h0_0000_0000, 36'h0_8001_0001, 36'h9_8001_8000, 36'h9_0106_0100,
    36'h9_0000_0000, 36'h2_0300_0200, 36'h2_0300_0100
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic s, input logic [2:0] m, input logic [15:0] r,
                       input logic we, input logic [1:0] wa, input logic [31:0] wd,
                       input logic ld);
    @(negedge clk);
    strict_en = s; mode_sel = m; req = r;
    cfg_wr_en = we; cfg_wr_addr = wa; cfg_wr_data = wd; load_cmd = ld;
    #1;
  endtask

  function automatic logic [15:0] slot_oh(input int ph, input logic [15:0] r);
    logic [3:0] o;
    o = exp_words[ph / 8][(ph % 8) * 4 +: 4];
    return (16'h1 << o) & r;
  endfunction

  task automatic sweep(input int n, input logic [15:0] r, input string tag);
    for (int k = 0; k < n; k++) begin
      drive(1'b0, 3'b001, r, 1'b0, 2'd0, 32'h0, 1'b0);
      chk({tag, " R8 gnt"}, {16'h0, gnt}, {16'h0, slot_oh(exp_phase, r)});
      chk("R8 phase", {27'h0, phase_ptr}, exp_phase);
      chk("R9 gnt within req", {16'h0, gnt & ~r}, 32'h0);
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++; checks++;
    $display("FAIL watchdog R1 actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int w = 0; w < 4; w++) exp_words[w] = 32'h0;
    rst_n = 1'b0; strict_en = 1'b0; mode_sel = 3'b000; req = '0;
    cfg_wr_en = 1'b0; cfg_wr_addr = '0; cfg_wr_data = '0; load_cmd = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; #1;
    // R1 reset state
    chk("R1 gnt", {16'h0, gnt}, 32'h0);
    chk("R1 pending", {31'h0, tbl_pending}, 32'h0);
    chk("R1 busy", {31'h0, load_busy}, 32'h0);
    chk("R1 phase", {27'h0, phase_ptr}, 32'h0);

    // R5 R6 R7 vector walk
    for (int i = 0; i < 11; i++) begin
      drive(VEC[i][35], VEC[i][34:32], VEC[i][31:16], 1'b0, 2'd0, 32'h0, 1'b0);
      chk($sformatf("R5/R6/R7 vec%0d", i), {16'h0, gnt}, {16'h0, VEC[i][15:0]});
    end
    chk("R8 phase holds off-mode", {27'h0, phase_ptr}, 32'h0);

    // R2 staged writes
    drive(1'b0, 3'b000, 16'h0, 1'b1, 2'd0, 32'h76543210, 1'b0);
    drive(1'b0, 3'b000, 16'h0, 1'b1, 2'd1, 32'hFEDCBA98, 1'b0);
    chk("R2 pending after write", {31'h0, tbl_pending}, 32'h1);
    drive(1'b0, 3'b000, 16'h0, 1'b1, 2'd2, 32'h33333333, 1'b0);
    drive(1'b0, 3'b000, 16'h0, 1'b1, 2'd3, 32'h55555555, 1'b0);
    // R2 working schedule still zero: slot owner is channel 0
    drive(1'b0, 3'b001, 16'hFFFF, 1'b0, 2'd0, 32'h0, 1'b0);
    chk("R2 unloaded table unused", {16'h0, gnt}, 32'h0001);
    drive(1'b0, 3'b000, 16'h0, 1'b0, 2'd0, 32'h0, 1'b0);
    chk("R8 phase stepped once", {27'h0, phase_ptr}, 32'h1);

    // R3 load sequence
    drive(1'b0, 3'b000, 16'h0, 1'b0, 2'd0, 32'h0, 1'b1);
    chk("R3 busy before edge", {31'h0, load_busy}, 32'h0);
    drive(1'b0, 3'b000, 16'h0, 1'b0, 2'd0, 32'h0, 1'b0);
    chk("R3 busy", {31'h0, load_busy}, 32'h1);
    chk("R3 pending during copy", {31'h0, tbl_pending}, 32'h1);
    drive(1'b0, 3'b000, 16'h0, 1'b0, 2'd0, 32'h0, 1'b0);
    chk("R3 busy falls", {31'h0, load_busy}, 32'h0);
    chk("R3 pending clears", {31'h0, tbl_pending}, 32'h0);
    exp_words[0] = 32'h76543210; exp_words[1] = 32'hFEDCBA98;
    exp_words[2] = 32'h33333333; exp_words[3] = 32'h55555555;

    // R8 full sweep with wrap, then a single requester
    sweep(40, 16'hFFFF, "all-req");
    sweep(32, 16'h0008, "ch3-only");

    // R4 write lands in the copy cycle
    drive(1'b0, 3'b000, 16'h0, 1'b1, 2'd3, 32'h11111111, 1'b0);
    drive(1'b0, 3'b000, 16'h0, 1'b0, 2'd0, 32'h0, 1'b1);
    drive(1'b0, 3'b000, 16'h0, 1'b1, 2'd2, 32'h22222222, 1'b0);
    chk("R4 busy in overlap", {31'h0, load_busy}, 32'h1);
    drive(1'b0, 3'b000, 16'h0, 1'b0, 2'd0, 32'h0, 1'b0);
    chk("R4 pending kept", {31'h0, tbl_pending}, 32'h1);
    chk("R4 busy falls", {31'h0, load_busy}, 32'h0);
    exp_words[3] = 32'h11111111;
    sweep(32, 16'hFFFF, "R4 old word");

    drive(1'b0, 3'b000, 16'h0, 1'b0, 2'd0, 32'h0, 1'b1);
    drive(1'b0, 3'b000, 16'h0, 1'b0, 2'd0, 32'h0, 1'b0);
    drive(1'b0, 3'b000, 16'h0, 1'b0, 2'd0, 32'h0, 1'b0);
    chk("R3 second load clears", {31'h0, tbl_pending}, 32'h0);
    exp_words[2] = 32'h22222222;
    sweep(32, 16'hFFFF, "R4 new word");

    // R5 strict overrides table select; R7 history follows last grant
    drive(1'b1, 3'b001, 16'h0024, 1'b0, 2'd0, 32'h0, 1'b0);
    chk("R6 strict highest", {16'h0, gnt}, 32'h0020);
    drive(1'b0, 3'b111, 16'h0024, 1'b0, 2'd0, 32'h0, 1'b0);
    chk("R7 rotate after 5", {16'h0, gnt}, 32'h0004);

    @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule